// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

The block turns a 32-bit linear address into a physical address. The top ten bits pick an entry in a page directory, the next ten pick an entry in the page table that entry points to, and the low twelve bits pass through as the byte offset. Both table reads go out through a single memory request port, and the memory answers on a response port. The walk checks the present bit at each level and applies the user/supervisor and read/write rules, using the more restrictive setting of the two levels. A fault records the faulting linear address in a fault-address register. On a walk that succeeds, the block writes the accessed flag back into each entry that does not yet have it. On a write access it also writes the dirty flag into the page table entry.

A small fully associative translation cache is searched in the same cycle the request is accepted. A hit that needs nothing written to memory returns the answer in the next cycle and sends no memory request. New translations fill the cache in round-robin order. A flush pulse clears every entry, and the owner pulses it whenever the directory base changes.

Each request enters on a valid/ready handshake. The block raises `req_ready` only while idle and accepts one request at a time. The result is held with all its fields stable until `res_ready` is seen. A memory request is held with its address and data stable until `mem_req_ready` is seen. Reads complete on a one-cycle `mem_rsp_valid` pulse. Writes complete at the handshake and get no response. `mem_rsp_valid` must never arrive unless a read is outstanding.

Top module: `xlat_walker`

## Requirements
- R1: The directory entry is read at `dir_base + 4*lin[31:22]`. The page table entry is read at `{pde[31:12],12'h000} + 4*lin[21:12]`. Reads carry `mem_req_we`=0.
- R2: On success `res_phys` = `{pte[31:12], lin[11:0]}` and `res_fault` = 0.
- R3: If bit 0 (present) of either entry is 0, the walk ends with `res_fault`=1 and no writes to memory. A missing directory entry ends the walk after one read. `fault_addr` takes the linear address.
- R4: A user request (`req_user`=1) faults when bit 2 (user) of either entry is 0. A user write also faults when bit 1 (writable) of either entry is 0. The same rule holds for an answer that comes from the cache.
- R5: A supervisor request (`req_user`=0) with both entries present succeeds whatever bits 1 and 2 hold.
- R6: After a successful walk, bit 5 (accessed) is written into each entry where it was 0. On a write, bit 6 (dirty) is also written into the page table entry. An entry that already has the needed bits gets no write.
- R7: A cache hit returns the cached translation and issues no memory read.
- R8: A write that hits a cached entry without the dirty mark walks the tables again. That walk sets the dirty bit in memory. Later writes to that page then hit.
- R9: The cache holds `TLB_DEPTH` translations and replaces them in round-robin order. A refill of an entry that is already cached reuses its slot.
- R10: A `flush` pulse invalidates every cached entry, so the next access walks again.
- R11: `req_ready` is high only while idle. A result that is not yet taken keeps `res_valid`, `res_phys` and `res_fault` stable. A memory request that is not yet taken keeps its valid, address, write flag and data stable.
- R12: `fault_addr` resets to 0 and changes only when a faulting result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical base of the page directory |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block accepts a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user (privilege 3), 0 = supervisor |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_phys | output | 32 | Physical address |
| res_fault | output | 1 | Translation faulted |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Word address of the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench builds the walker with `TLB_DEPTH` = 4 instead of 32. Four successful walks then fill the cache, and a fifth shows which translation is evicted and which survives. The memory port and the result port are stalled in fixed repeating patterns, so both hold rules are exercised on most transfers. Read and write counts and the table words in the bench memory show which accesses walked, which hit, and which accessed or dirty bits were written back.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int LVL_W = 10;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY = 6;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic             usr_ok;
    logic             wr_ok;
    logic             dirty;
  } tlb_ent_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PDE_RD, S_PDE_WT, S_PTE_RD, S_PTE_WT, S_PDE_WB, S_PTE_WB, S_FILL
  } walk_st_t;
endpackage

// File: rtl/xw_perm.sv
module xw_perm (
  input  logic user,
  input  logic write,
  input  logic us_bit,
  input  logic rw_bit,
  output logic allow
);
  always_comb allow = !user || (us_bit && (!write || rw_bit));
endmodule

// File: rtl/xw_tlb.sv
module xw_tlb
  import xw_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output tlb_ent_t         hit_ent,
  input  logic             fill_en,
  input  logic             fill_reuse,
  input  logic [IW-1:0]    fill_idx,
  input  tlb_ent_t         fill_ent
);
  tlb_ent_t         ents [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [IW-1:0]    ptr;
  logic [IW-1:0]    slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld[g] && (ents[g].vpn == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_idx = IW'(i);
  end

  assign hit     = |match;
  assign hit_ent = ents[hit_idx];
  assign slot    = fill_reuse ? fill_idx : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill_en) begin
      vld[slot] <= 1'b1;
      if (!fill_reuse) ptr <= (ptr == IW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (fill_en) ents[slot] <= fill_ent;

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int TLB_DEPTH = 32,
  localparam int IW = (TLB_DEPTH > 1) ? $clog2(TLB_DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dir_base,
  input  logic        flush,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_phys,
  output logic        res_fault,
  output logic [31:0] fault_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  output logic        mem_req_we,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  walk_st_t    st;
  logic [31:0] lin_q, pde_q, pte_q;
  logic        wr_q, usr_q, reuse_q;
  logic [IW-1:0] reuse_idx_q;
  logic        done_q;

  logic        hit;
  logic [IW-1:0] hit_idx;
  tlb_ent_t    hit_ent, fill_ent;
  logic        fill_en;
  logic        hit_allow, walk_allow;
  logic [31:0] pde_addr, pte_addr, pte_new;
  logic        pte_needs_wb;

  xw_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_lin[31:OFF_W]), .hit(hit), .hit_idx(hit_idx), .hit_ent(hit_ent),
    .fill_en(fill_en), .fill_reuse(reuse_q), .fill_idx(reuse_idx_q), .fill_ent(fill_ent)
  );

  xw_perm u_hit_perm (
    .user(req_user), .write(req_write),
    .us_bit(hit_ent.usr_ok), .rw_bit(hit_ent.wr_ok), .allow(hit_allow)
  );

  xw_perm u_walk_perm (
    .user(usr_q), .write(wr_q),
    .us_bit(pde_q[BIT_USER] & mem_rsp_data[BIT_USER]),
    .rw_bit(pde_q[BIT_WRITABLE] & mem_rsp_data[BIT_WRITABLE]),
    .allow(walk_allow)
  );

  assign pde_addr = dir_base + {20'd0, lin_q[31:32-LVL_W], 2'b00};
  assign pte_addr = {pde_q[31:OFF_W], {OFF_W{1'b0}}} + {20'd0, lin_q[31-LVL_W:OFF_W], 2'b00};
  assign pte_new  = pte_q | (32'd1 << BIT_ACCESSED) | ({31'd0, wr_q} << BIT_DIRTY);
  assign pte_needs_wb = !pte_q[BIT_ACCESSED] || (wr_q && !pte_q[BIT_DIRTY]);

  assign fill_en = (st == S_FILL);
  always_comb begin
    fill_ent.vpn    = lin_q[31:OFF_W];
    fill_ent.ppn    = pte_q[31:OFF_W];
    fill_ent.usr_ok = pde_q[BIT_USER] & pte_q[BIT_USER];
    fill_ent.wr_ok  = pde_q[BIT_WRITABLE] & pte_q[BIT_WRITABLE];
    fill_ent.dirty  = pte_q[BIT_DIRTY] | wr_q;
  end

  assign req_ready = (st == S_IDLE) && !done_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = pde_addr;
    mem_req_we    = 1'b0;
    mem_req_wdata = '0;
    unique case (st)
      S_PDE_RD: mem_req_valid = 1'b1;
      S_PTE_RD: begin mem_req_valid = 1'b1; mem_req_addr = pte_addr; end
      S_PDE_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = pde_q | (32'd1 << BIT_ACCESSED);
      end
      S_PTE_WB: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = pte_addr;
        mem_req_we    = 1'b1;
        mem_req_wdata = pte_new;
      end
      default: ;
    endcase
  end

  assign res_valid = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done_q <= 1'b0; res_phys <= '0; res_fault <= 1'b0;
      fault_addr <= '0; lin_q <= '0; pde_q <= '0; pte_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; reuse_q <= 1'b0; reuse_idx_q <= '0;
    end else begin
      if (done_q && res_ready) done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid && req_ready) begin
          lin_q <= req_lin; wr_q <= req_write; usr_q <= req_user;
          reuse_q <= 1'b0; reuse_idx_q <= hit_idx;
          if (hit && !hit_allow) begin
            done_q <= 1'b1; res_fault <= 1'b1; res_phys <= '0; fault_addr <= req_lin;
          end else if (hit && req_write && !hit_ent.dirty) begin
            reuse_q <= 1'b1;
            st <= S_PDE_RD;
          end else if (hit) begin
            done_q <= 1'b1; res_fault <= 1'b0;
            res_phys <= {hit_ent.ppn, req_lin[OFF_W-1:0]};
          end else begin
            st <= S_PDE_RD;
          end
        end
        S_PDE_RD: if (mem_req_ready) st <= S_PDE_WT;
        S_PDE_WT: if (mem_rsp_valid) begin
          pde_q <= mem_rsp_data;
          if (!mem_rsp_data[BIT_PRESENT]) begin
            st <= S_IDLE; done_q <= 1'b1; res_fault <= 1'b1; res_phys <= '0;
            fault_addr <= lin_q;
          end else st <= S_PTE_RD;
        end
        S_PTE_RD: if (mem_req_ready) st <= S_PTE_WT;
        S_PTE_WT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          if (!mem_rsp_data[BIT_PRESENT] || !walk_allow) begin
            st <= S_IDLE; done_q <= 1'b1; res_fault <= 1'b1; res_phys <= '0;
            fault_addr <= lin_q;
          end else begin
            res_phys <= {mem_rsp_data[31:OFF_W], lin_q[OFF_W-1:0]};
            res_fault <= 1'b0;
            if (!pde_q[BIT_ACCESSED]) st <= S_PDE_WB;
            else if (!mem_rsp_data[BIT_ACCESSED] || (wr_q && !mem_rsp_data[BIT_DIRTY]))
              st <= S_PTE_WB;
            else st <= S_FILL;
          end
        end
        S_PDE_WB: if (mem_req_ready) st <= pte_needs_wb ? S_PTE_WB : S_FILL;
        S_PTE_WB: if (mem_req_ready) st <= S_FILL;
        S_FILL: begin st <= S_IDLE; done_q <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_phys) && $stable(res_fault)));
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid && !mem_req_valid));
  p_fault_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (res_valid && res_fault));
  p_hit_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit && !(req_write && !hit_ent.dirty)) |=>
      (res_valid && !mem_req_valid));
  p_wb_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> !res_valid);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0001_0000;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0;
  logic req_ready, res_valid, res_fault, mem_req_valid, mem_req_we;
  logic res_ready = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] res_phys, fault_addr, mem_req_addr, mem_req_wdata;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  xlat_walker #(.TLB_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .res_valid(res_valid), .res_ready(res_ready), .res_phys(res_phys),
    .res_fault(res_fault), .fault_addr(fault_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct { logic [31:0] phys; logic fault; string tag; } exp_t;
  exp_t exp_q[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log[$];
  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, got = 0, cyc = 0;
  logic pend = 1'b0, held = 1'b0;
  logic [31:0] pend_data = '0, held_phys = '0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model, result monitor, stall patterns, watchdog
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finish_run();
    end
    mem_rsp_valid = pend;
    mem_rsp_data  = pend_data;
    pend = 1'b0;
    mem_req_ready = rst_n && (cyc % 3 != 0);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
      end else begin
        pend = 1'b1;
        pend_data = mrd(mem_req_addr);
        rd_log.push_back(mem_req_addr);
        rd_cnt++;
      end
    end
    if (held) begin
      chk("R11 result held", {31'd0, res_valid}, 32'd1);
      chk("R11 phys stable", res_phys, held_phys);
    end
    res_ready = rst_n && (cyc % 4 != 1);
    held = res_valid && !res_ready;
    held_phys = res_phys;
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " fault"}, {31'd0, res_fault}, {31'd0, e.fault});
        if (!e.fault) chk({e.tag, " phys"}, res_phys, e.phys);
      end
      got++;
    end
  end

  task automatic xact(input logic [31:0] lin, input logic wr, input logic usr,
                      input logic [31:0] ephys, input logic efault, input string tag);
    exp_t e;
    int want;
    want = got + 1;
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    e.phys = ephys; e.fault = efault; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    while (got < want) @(negedge clk);
  endtask

  int r0, w0;
  task automatic mark(); r0 = rd_cnt; w0 = wr_cnt; endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_0008] = 32'h9ABC_D007;
    mem[32'h0002_000C] = 32'h0;
    mem[32'h0001_0000] = 32'h0;
    mem[32'h0002_0010] = 32'h1111_1003;
    mem[32'h0002_0014] = 32'h2222_2005;
    mem[32'h0001_0008] = 32'h0003_0005;
    mem[32'h0003_0000] = 32'h3333_3007;
    mem[32'h0002_0018] = 32'h4444_4007;
    repeat (3) @(negedge clk);
    chk("R11 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R11 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R12 reset fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle ready", {31'd0, req_ready}, 32'd1);

    mark(); xact(32'h0040_2100, 0, 0, 32'h9ABC_D100, 0, "R2 first walk");
    chk("R1 read count", rd_cnt - r0, 2);
    chk("R1 pde addr", rd_log[r0], 32'h0001_0004);
    chk("R1 pte addr", rd_log[r0+1], 32'h0002_0008);
    chk("R6 writes", wr_cnt - w0, 2);
    chk("R6 pde accessed", mrd(32'h0001_0004), 32'h0002_0027);
    chk("R6 pte accessed", mrd(32'h0002_0008), 32'h9ABC_D027);

    mark(); xact(32'h0040_2100, 0, 0, 32'h9ABC_D100, 0, "R7 hit");
    chk("R7 no reads on hit", rd_cnt - r0, 0);

    mark(); xact(32'h0040_2FFC, 1, 1, 32'h9ABC_DFFC, 0, "R8 write clean hit");
    chk("R8 rewalk reads", rd_cnt - r0, 2);
    chk("R6 only pte written", wr_cnt - w0, 1);
    chk("R6 pte dirty", mrd(32'h0002_0008), 32'h9ABC_D067);

    mark(); xact(32'h0040_2004, 1, 1, 32'h9ABC_D004, 0, "R8 write dirty hit");
    chk("R8 no reads", rd_cnt - r0, 0);

    mark(); xact(32'h0040_3ABC, 0, 0, 32'h0, 1, "R3 pte absent");
    chk("R3 fault_addr", fault_addr, 32'h0040_3ABC);
    chk("R3 no writes", wr_cnt - w0, 0);

    mark(); xact(32'h0000_0123, 0, 0, 32'h0, 1, "R3 pde absent");
    chk("R3 one read", rd_cnt - r0, 1);
    chk("R3 fault_addr pde", fault_addr, 32'h0000_0123);

    xact(32'h0040_4008, 0, 1, 32'h0, 1, "R4 user on supervisor page");
    xact(32'h0040_4008, 0, 0, 32'h1111_1008, 0, "R5 supervisor on supervisor page");
    chk("R6 sup pte accessed", mrd(32'h0002_0010), 32'h1111_1023);
    mark(); xact(32'h0040_4008, 0, 1, 32'h0, 1, "R4 user fault from cache");
    chk("R4 cache fault no reads", rd_cnt - r0, 0);

    xact(32'h0040_5010, 1, 1, 32'h0, 1, "R4 user write read-only");
    xact(32'h0040_5020, 1, 0, 32'h2222_2020, 0, "R5 supervisor write read-only");
    chk("R6 pte accessed dirty", mrd(32'h0002_0014), 32'h2222_2065);
    chk("R12 fault_addr kept", fault_addr, 32'h0040_5010);

    xact(32'h0080_0010, 1, 1, 32'h0, 1, "R4 directory read-only");
    xact(32'h0080_0010, 0, 1, 32'h3333_3010, 0, "R4 user read allowed");
    chk("R6 pde2 accessed", mrd(32'h0001_0008), 32'h0003_0025);

    xact(32'h0040_6444, 0, 0, 32'h4444_4444, 0, "R9 fifth fill");
    mark(); xact(32'h0080_0FF0, 0, 1, 32'h3333_3FF0, 0, "R9 survivor hit");
    chk("R9 survivor no reads", rd_cnt - r0, 0);
    mark(); xact(32'h0040_2100, 0, 0, 32'h9ABC_D100, 0, "R9 evicted rewalk");
    chk("R9 evicted walks", rd_cnt - r0, 2);
    chk("R6 no write when set", wr_cnt - w0, 0);

    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    mark(); xact(32'h0080_0010, 0, 1, 32'h3333_3010, 0, "R10 after flush");
    chk("R10 walks after flush", rd_cnt - r0, 2);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule